// File: doc/BRIEF.md
# Boolean Instruction Execution Unit

This unit carries out the sixteen two-operand bitwise instructions of a 36-bit word machine once address evaluation has produced the effective address E. The instruction opcode for this group is `1 0 0 F F F F M M`. A 4-bit function code picks one of the sixteen ways to combine the accumulator with an operand. A 2-bit mode code picks where the operand comes from and where the result goes. The accumulators are the low words of the same memory the unit reads and writes. Accumulator n is the word at address n.

A sequencer takes the decoded fields on a start pulse and runs for a fixed number of clocks. It reads the accumulator, then reads the operand. The operand is either the memory word at E or the immediate word made of 18 zero bits above E. The sequencer then stores the result and returns to idle. The result goes to the accumulator, to memory at E, or to both. A one-cycle done pulse follows the last store. The unit works through a single memory port. A read issued in one cycle returns its data in the next cycle.

Top module: `bool_exec_unit`

## Requirements
- R1: While reset is low, and in the cycle after it is released, busy, done, the memory read strobe and the memory write strobe are all low. A reset taken in the middle of an instruction abandons it.
- R2: Result bit i equals bit number 3 − (2·operand_i + accumulator_i) of the function code. This gives the following codes: 0 zero, 1 acc AND op, 2 NOT acc AND op, 3 op, 4 acc AND NOT op, 5 acc, 6 XOR, 7 OR, 8 NOR, 9 XNOR, 10 NOT acc, 11 NOT acc OR op, 12 NOT op, 13 acc OR NOT op, 14 NAND, 15 all ones.
- R3: Mode 00 takes the operand from the memory word at E and writes the result to the accumulator word (address = accumulator number, zero-extended). No other word changes.
- R4: Mode 01 uses the operand {18 zero bits, E}. E is never read. The instruction makes exactly one memory read, the accumulator, and the result goes to the accumulator.
- R5: Mode 10 reads memory at E and writes the result to memory at E. The accumulator and all other words are left unchanged.
- R6: Mode 11 reads memory at E and writes the result to both locations. The accumulator store comes first and the store at E comes in the next cycle.
- R7: Done goes high 3 rising edges after the edge that accepted start for modes 00, 01 and 10, and 4 edges after it for mode 11.
- R8: Done is high for exactly one cycle per instruction.
- R9: A start pulse while busy has no effect. The running instruction completes unchanged, and the ignored request makes no access and raises no done.
- R10: Memory port rules:
  - The first busy cycle is a read of the accumulator word.
  - Read and write strobes are never high together.
  - No access is made while idle.
  - A store is followed either by a second store or by done, never by a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Request to execute the presented instruction |
| func_i | input | 4 | Boolean function code |
| mode_i | input | 2 | Operand/destination mode |
| acc_i | input | 4 | Accumulator number |
| ea_i | input | 18 | Effective address E |
| busy_o | output | 1 | Instruction in progress |
| done_o | output | 1 | One-cycle pulse after the final store |
| mem_addr_o | output | 18 | Memory word address |
| mem_rd_o | output | 1 | Read strobe; data returns the next cycle |
| mem_we_o | output | 1 | Write strobe |
| mem_wdata_o | output | 36 | Write data |
| mem_rdata_i | input | 36 | Read data, valid the cycle after a read |

## Verification
The assertions take three things for granted about the inputs:
- Start is sampled only on clock edges.
- Memory returns read data exactly one cycle after a read strobe.
- Reset is synchronous.

The bench's memory model follows the one-cycle read contract. It keeps every memory-mode E, and every accumulator, inside its 32 modelled words, while immediate-mode E spans the full 18-bit range. Start is driven on falling edges, held for one accepting cycle, and is pulsed during busy only in the test for R9.

// File: rtl/bool_exec_pkg.sv
// Shared types for the boolean execution unit.
// Assumes: none beyond SystemVerilog 2017 enums.
package bool_exec_pkg;

    // Operand source / result destination selector
    typedef enum logic [1:0] {
        MODE_NORMAL = 2'b00,
        MODE_IMMED  = 2'b01,
        MODE_MEMORY = 2'b10,
        MODE_BOTH   = 2'b11
    } bx_mode_e;

    // Sequencer phases, one clock each
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH_AC,
        ST_FETCH_OP,
        ST_STORE_A,
        ST_STORE_B
    } bx_state_e;

    // Source chosen for the working register
    typedef enum logic [1:0] {
        AR_HOLD,
        AR_LOAD_MEM,
        AR_LOAD_FN
    } bx_ar_sel_e;

endpackage

// File: rtl/bool_logic_unit.sv
// Bitwise sixteen-function combiner.
// Each result bit indexes the 4-bit function code with the inverted
// {operand, accumulator} bit pair, so the code itself is the truth table.
// Assumes: purely combinational use, no registers.
module bool_logic_unit #(
    parameter int WORD_W = 36
) (
    input  logic [3:0]        fcode_i,
    input  logic [WORD_W-1:0] acc_val_i,
    input  logic [WORD_W-1:0] opnd_val_i,
    output logic [WORD_W-1:0] result_o
);

    // One four-input lookup per bit position
    for (genvar g = 0; g < WORD_W; g++) begin : g_bit
        logic [1:0] sel;
        assign sel         = ~{opnd_val_i[g], acc_val_i[g]};
        assign result_o[g] = fcode_i[sel];
    end

endmodule

// File: rtl/bool_exec_ctrl.sv
// Sequencer for one boolean instruction.
// Steps idle -> fetch accumulator -> fetch operand -> store, with a
// second store for the both-destinations mode, then pulses done.
// Assumes: mode_q_i is the mode latched on the accepting edge.
module bool_exec_ctrl
    import bool_exec_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      start_i,
    input  bx_mode_e  mode_q_i,
    output bx_state_e state_o,
    output logic      accept_o,
    output logic      busy_o,
    output logic      done_o
);

    bx_state_e state_q, state_d;
    logic      done_q, done_d;

    // Start is taken only from idle
    assign accept_o = start_i && (state_q == ST_IDLE);

    // Next-phase selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (start_i) state_d = ST_FETCH_AC;
            ST_FETCH_AC: state_d = ST_FETCH_OP;
            ST_FETCH_OP: state_d = ST_STORE_A;
            ST_STORE_A:  state_d = (mode_q_i == MODE_BOTH) ? ST_STORE_B : ST_IDLE;
            ST_STORE_B:  state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    // Done follows the last store of the instruction
    always_comb begin
        done_d = ((state_q == ST_STORE_A) && (mode_q_i != MODE_BOTH))
               || (state_q == ST_STORE_B);
    end

    // Phase and done registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            done_q  <= done_d;
        end
    end

    assign state_o = state_q;
    assign busy_o  = (state_q != ST_IDLE);
    assign done_o  = done_q;

endmodule

// File: rtl/bool_exec_path.sv
// Data path of the boolean unit.
// Holds the latched instruction fields and the working register.
// Chooses the operand (memory data or zero-extended E) and drives the
// shared memory port in each phase.
// Assumes: memory read data is valid the cycle after a read strobe;
// WORD_W >= ADDR_W >= AC_W.
module bool_exec_path
    import bool_exec_pkg::*;
#(
    parameter int WORD_W = 36,
    parameter int ADDR_W = 18,
    parameter int AC_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept_i,
    input  bx_state_e         state_i,
    input  logic [3:0]        func_i,
    input  logic [1:0]        mode_i,
    input  logic [AC_W-1:0]   acc_i,
    input  logic [ADDR_W-1:0] ea_i,
    output bx_mode_e          mode_q_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic              mem_rd_o,
    output logic              mem_we_o,
    output logic [WORD_W-1:0] mem_wdata_o,
    input  logic [WORD_W-1:0] mem_rdata_i
);

    localparam int IMM_PAD = WORD_W - ADDR_W;
    localparam int ACC_PAD = ADDR_W - AC_W;

    logic [3:0]        func_q;
    bx_mode_e          mode_q;
    logic [AC_W-1:0]   acc_q;
    logic [ADDR_W-1:0] ea_q;
    logic [WORD_W-1:0] ar_q;
    logic [WORD_W-1:0] opnd;
    logic [WORD_W-1:0] fn_out;
    logic [ADDR_W-1:0] acc_addr;
    bx_ar_sel_e        ar_sel;

    // Capture the decoded instruction on the accepting edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            func_q <= '0;
            mode_q <= MODE_NORMAL;
            acc_q  <= '0;
            ea_q   <= '0;
        end else if (accept_i) begin
            func_q <= func_i;
            mode_q <= bx_mode_e'(mode_i);
            acc_q  <= acc_i;
            ea_q   <= ea_i;
        end
    end

    assign acc_addr = {{ACC_PAD{1'b0}}, acc_q};

    // Operand: immediate word or memory data returned this cycle
    always_comb begin
        opnd = (mode_q == MODE_IMMED) ? {{IMM_PAD{1'b0}}, ea_q} : mem_rdata_i;
    end

    bool_logic_unit #(.WORD_W(WORD_W)) i_logic (
        .fcode_i    (func_q),
        .acc_val_i  (ar_q),
        .opnd_val_i (opnd),
        .result_o   (fn_out)
    );

    // Working register source per phase
    always_comb begin
        unique case (state_i)
            ST_FETCH_OP: ar_sel = AR_LOAD_MEM;
            ST_STORE_A:  ar_sel = AR_LOAD_FN;
            default:     ar_sel = AR_HOLD;
        endcase
    end

    // Working register: accumulator value, then result
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ar_q <= '0;
        end else begin
            unique case (ar_sel)
                AR_LOAD_MEM: ar_q <= mem_rdata_i;
                AR_LOAD_FN:  ar_q <= fn_out;
                default:     ar_q <= ar_q;
            endcase
        end
    end

    // Memory port drive per phase
    always_comb begin
        mem_addr_o  = '0;
        mem_rd_o    = 1'b0;
        mem_we_o    = 1'b0;
        mem_wdata_o = '0;
        unique case (state_i)
            ST_FETCH_AC: begin
                mem_addr_o = acc_addr;
                mem_rd_o   = 1'b1;
            end
            ST_FETCH_OP: begin
                mem_addr_o = ea_q;
                mem_rd_o   = (mode_q != MODE_IMMED);
            end
            ST_STORE_A: begin
                mem_addr_o  = (mode_q == MODE_MEMORY) ? ea_q : acc_addr;
                mem_we_o    = 1'b1;
                mem_wdata_o = fn_out;
            end
            ST_STORE_B: begin
                mem_addr_o  = ea_q;
                mem_we_o    = 1'b1;
                mem_wdata_o = ar_q;
            end
            default: ;
        endcase
    end

    assign mode_q_o = mode_q;

endmodule

// File: rtl/bool_exec_unit.sv
// Top of the boolean instruction execution unit.
// Joins the sequencer and the data path around one shared memory port.
// Assumes: accumulators occupy the lowest 2**AC_W memory words.
module bool_exec_unit
    import bool_exec_pkg::*;
#(
    parameter int WORD_W = 36,
    parameter int ADDR_W = 18,
    parameter int AC_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [3:0]        func_i,
    input  logic [1:0]        mode_i,
    input  logic [AC_W-1:0]   acc_i,
    input  logic [ADDR_W-1:0] ea_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic              mem_rd_o,
    output logic              mem_we_o,
    output logic [WORD_W-1:0] mem_wdata_o,
    input  logic [WORD_W-1:0] mem_rdata_i
);

    bx_state_e state;
    bx_mode_e  mode_q;
    logic      accept;

    bool_exec_ctrl i_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .mode_q_i (mode_q),
        .state_o  (state),
        .accept_o (accept),
        .busy_o   (busy_o),
        .done_o   (done_o)
    );

    bool_exec_path #(
        .WORD_W (WORD_W),
        .ADDR_W (ADDR_W),
        .AC_W   (AC_W)
    ) i_path (
        .clk         (clk),
        .rst_n       (rst_n),
        .accept_i    (accept),
        .state_i     (state),
        .func_i      (func_i),
        .mode_i      (mode_i),
        .acc_i       (acc_i),
        .ea_i        (ea_i),
        .mode_q_o    (mode_q),
        .mem_addr_o  (mem_addr_o),
        .mem_rd_o    (mem_rd_o),
        .mem_we_o    (mem_we_o),
        .mem_wdata_o (mem_wdata_o),
        .mem_rdata_i (mem_rdata_i)
    );

endmodule

// File: rtl/bool_exec_unit_chk.sv
// Port-level protocol checker for bool_exec_unit, attached by bind.
// Assumes: synchronous active-low reset.
module bool_exec_unit_chk #(
    parameter int ADDR_W = 18,
    parameter int AC_W   = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy_o,
    input logic              done_o,
    input logic              mem_rd_o,
    input logic              mem_we_o,
    input logic [ADDR_W-1:0] mem_addr_o
);

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R10
    rd_we_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd_o && mem_we_o));

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!mem_rd_o && !mem_we_o));

    // R10
    first_read_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> (mem_rd_o && (mem_addr_o[ADDR_W-1:AC_W] == '0)));

    // R7
    store_then_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |=> (mem_we_o != done_o));

    // R6
    two_store_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we_o && $past(mem_we_o)) |=> !mem_we_o);

    // R9
    done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(busy_o));

endmodule

bind bool_exec_unit bool_exec_unit_chk #(
    .ADDR_W (ADDR_W),
    .AC_W   (AC_W)
) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .mem_rd_o   (mem_rd_o),
    .mem_we_o   (mem_we_o),
    .mem_addr_o (mem_addr_o)
);

// File: tb/test_bool_exec_unit.sv
`timescale 1ns/1ps
// Self-checking bench: vector table loop, then directed reset and busy tests.
module test_bool_exec_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [3:0]  func = '0;
    logic [1:0]  mode = '0;
    logic [3:0]  acc = '0;
    logic [17:0] ea = '0;
    logic        busy, done, mem_rd, mem_we;
    logic [17:0] mem_addr;
    logic [35:0] mem_wdata;
    logic [35:0] mem_rdata;

    int n_chk = 0;
    int n_fail = 0;
    int rd_total = 0;
    int wr_total = 0;
    logic [17:0] wlog_prev = '0;
    logic [17:0] wlog_last = '0;

    logic [35:0] mem [32];
    logic [35:0] exp_mem [32];

    always #4 clk = ~clk;

    bool_exec_unit i_bool_exec_unit (
        .clk (clk), .rst_n (rst_n), .start_i (start), .func_i (func),
        .mode_i (mode), .acc_i (acc), .ea_i (ea), .busy_o (busy),
        .done_o (done), .mem_addr_o (mem_addr), .mem_rd_o (mem_rd),
        .mem_we_o (mem_we), .mem_wdata_o (mem_wdata), .mem_rdata_i (mem_rdata)
    );

    function automatic logic [35:0] init_word(int i);
        return {9{4'(i)}} ^ 36'h93C5A6E17 ^ (36'(i) << 20);
    endfunction

    // Memory model: registered read, logs reads and writes
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 32; i++) mem[i] <= init_word(i);
            mem_rdata <= '0;
        end else begin
            if (mem_rd) begin
                mem_rdata <= mem[mem_addr[4:0]];
                rd_total  <= rd_total + 1;
            end
            if (mem_we) begin
                mem[mem_addr[4:0]] <= mem_wdata;
                wr_total  <= wr_total + 1;
                wlog_prev <= wlog_last;
                wlog_last <= mem_addr;
            end
        end
    end

    // Named boolean operations, written independently of the truth table
    function automatic logic [35:0] ref_fn(logic [3:0] f, logic [35:0] a, logic [35:0] o);
        case (f)
            4'd0:  return '0;
            4'd1:  return a & o;
            4'd2:  return ~a & o;
            4'd3:  return o;
            4'd4:  return a & ~o;
            4'd5:  return a;
            4'd6:  return a ^ o;
            4'd7:  return a | o;
            4'd8:  return ~(a | o);
            4'd9:  return ~(a ^ o);
            4'd10: return ~a;
            4'd11: return ~a | o;
            4'd12: return ~o;
            4'd13: return a | ~o;
            4'd14: return ~(a & o);
            default: return '1;
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [35:0] act, input logic [35:0] expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
        end
    endtask

    // {func, mode, acc, ea}
    localparam logic [27:0] VECS [18] = '{
        {4'd0,  2'b00, 4'd4,  18'd20},
        {4'd1,  2'b01, 4'd5,  18'h2AAAA},
        {4'd2,  2'b10, 4'd6,  18'd21},
        {4'd3,  2'b11, 4'd4,  18'd22},
        {4'd4,  2'b00, 4'd7,  18'd23},
        {4'd5,  2'b01, 4'd8,  18'h3FFFF},
        {4'd6,  2'b10, 4'd9,  18'd24},
        {4'd7,  2'b11, 4'd10, 18'd25},
        {4'd8,  2'b00, 4'd11, 18'd26},
        {4'd9,  2'b01, 4'd12, 18'h00001},
        {4'd10, 2'b10, 4'd13, 18'd27},
        {4'd11, 2'b11, 4'd14, 18'd28},
        {4'd12, 2'b00, 4'd15, 18'd3},
        {4'd13, 2'b01, 4'd0,  18'h01234},
        {4'd14, 2'b10, 4'd1,  18'd29},
        {4'd15, 2'b11, 4'd2,  18'd2},
        {4'd6,  2'b00, 4'd3,  18'd30},
        {4'd9,  2'b11, 4'd5,  18'd31}
    };

    task automatic run_vec(input logic [3:0] f, input logic [1:0] m,
                           input logic [3:0] a, input logic [17:0] e);
        logic [35:0] av, ov, rv;
        int rd0, wr0, k, bad;
        string tag;
        tag = (m == 2'b00) ? "R3" : (m == 2'b01) ? "R4" : (m == 2'b10) ? "R5" : "R6";
        av = mem[a];
        ov = (m == 2'b01) ? {18'b0, e} : mem[e[4:0]];
        rv = ref_fn(f, av, ov);
        for (int i = 0; i < 32; i++) exp_mem[i] = mem[i];
        if (m != 2'b10) exp_mem[a] = rv;
        if (m[1])       exp_mem[e[4:0]] = rv;
        rd0 = rd_total;
        wr0 = wr_total;
        @(negedge clk);
        func = f; mode = m; acc = a; ea = e; start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        k = 0;
        while (!done && k < 20) begin
            @(negedge clk);
            k++;
        end
        chk(k == ((m == 2'b11) ? 4 : 3), "R7", "done latency", 36'(k), (m == 2'b11) ? 36'd4 : 36'd3);
        @(negedge clk);
        chk(!done, "R8", "done width", 36'(done), 36'd0);
        chk((rd_total - rd0) == ((m == 2'b01) ? 1 : 2), tag, "read count",
            36'(rd_total - rd0), (m == 2'b01) ? 36'd1 : 36'd2);
        chk((wr_total - wr0) == ((m == 2'b11) ? 2 : 1), tag, "write count",
            36'(wr_total - wr0), (m == 2'b11) ? 36'd2 : 36'd1);
        if (m == 2'b11) begin
            chk(wlog_prev == 18'(a) && wlog_last == e, "R6", "store order acc then E",
                {wlog_prev, wlog_last}, {18'(a), e});
        end
        if (m == 2'b10) chk(mem[e[4:0]] == rv, "R2", $sformatf("func %0d result", f), mem[e[4:0]], rv);
        else            chk(mem[a] == rv, "R2", $sformatf("func %0d result", f), mem[a], rv);
        bad = 0;
        for (int i = 0; i < 32; i++) if (mem[i] !== exp_mem[i]) bad++;
        chk(bad == 0, tag, "untouched words", 36'(bad), 36'd0);
    endtask

    // Watchdog: a hung run is a failed check
    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL R7 watchdog expired actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [35:0] w9, rv;
        int dn;
        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(!busy && !done && !mem_rd && !mem_we, "R1", "outputs in reset",
            {busy, done, mem_rd, mem_we}, 36'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done && !mem_rd && !mem_we, "R1", "outputs after release",
            {busy, done, mem_rd, mem_we}, 36'd0);

        // Table walk covering every function and mode
        for (int v = 0; v < 18; v++) begin
            run_vec(VECS[v][27:24], VECS[v][23:22], VECS[v][21:18], VECS[v][17:0]);
        end

        // R9: start while busy is ignored
        w9 = mem[9];
        rv = ref_fn(4'd7, mem[3], mem[30]);
        @(negedge clk);
        func = 4'd7; mode = 2'b10; acc = 4'd3; ea = 18'd30; start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        func = 4'd0; mode = 2'b00; acc = 4'd9; ea = 18'd31;
        @(negedge clk);
        start = 1'b0;
        dn = 0;
        for (int c = 0; c < 12; c++) begin
            @(negedge clk);
            if (done) dn++;
        end
        chk(dn == 1, "R9", "done count", 36'(dn), 36'd1);
        chk(mem[30] == rv, "R9", "running instruction result", mem[30], rv);
        chk(mem[9] == w9, "R9", "ignored request left acc 9", mem[9], w9);
        chk(!busy, "R9", "idle afterwards", 36'(busy), 36'd0);

        // R1: reset in the middle of an instruction
        @(negedge clk);
        func = 4'd15; mode = 2'b11; acc = 4'd1; ea = 18'd20; start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(!busy && !done && !mem_rd && !mem_we, "R1", "mid-instruction reset",
            {busy, done, mem_rd, mem_we}, 36'd0);
        rst_n = 1'b1;
        dn = 0;
        for (int c = 0; c < 6; c++) begin
            @(negedge clk);
            if (done || busy) dn++;
        end
        chk(dn == 0, "R1", "abandoned instruction stays quiet", 36'(dn), 36'd0);

        // Back-to-back after reset
        run_vec(4'd6, 2'b11, 4'd7, 18'd7);
        run_vec(4'd12, 2'b01, 4'd15, 18'h20000);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule